// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

A purely combinational arithmetic slice for a datapath. One adder operand is always `op_a`. The other operand comes from a per-bit four-way selector. That selector presents `op_b`, the bitwise inverse of `op_b`, all zeros or all ones, as chosen by a two-bit code. The adder sums the two operands with a carry-in and returns an n-bit `result` and a `carry_out`, so `result + 2^n*carry_out = op_a + Y + carry_in`.

The eight pairs of code and carry-in give seven distinct operations. These are add, add plus one, subtract, subtract with borrow, pass-through, increment and decrement. Pass-through appears twice. The carry ripples from bit 0 to the top stage. The caller registers `result` wherever it needs to.

Top module: `arith_unit`

## Requirements
- R1: With `y_sel` = 2'b00 and `carry_in` = 0, `result` = (A + B) mod 2^n and `carry_out` = 1 exactly when A + B >= 2^n.
- R2: With `y_sel` = 2'b00 and `carry_in` = 1, `result` = (A + B + 1) mod 2^n and `carry_out` = 1 exactly when A + B + 1 >= 2^n.
- R3: With `y_sel` = 2'b01 and `carry_in` = 1, `result` = (A - B) mod 2^n and `carry_out` = 1 exactly when A >= B (no borrow).
- R4: With `y_sel` = 2'b01 and `carry_in` = 0, `result` = (A - B - 1) mod 2^n and `carry_out` = 1 exactly when A > B.
- R5: With `y_sel` = 2'b10 and `carry_in` = 0, `result` = A and `carry_out` = 0, whatever the value of B.
- R6: With `y_sel` = 2'b10 and `carry_in` = 1, `result` = (A + 1) mod 2^n and `carry_out` = 1 only when A is all ones. B has no effect.
- R7: With `y_sel` = 2'b11 and `carry_in` = 0, `result` = (A - 1) mod 2^n and `carry_out` = 1 exactly when A is nonzero. B has no effect.
- R8: With `y_sel` = 2'b11 and `carry_in` = 1, `result` = A and `carry_out` = 1, whatever the value of B.
- R9: The width n is the parameter `WIDTH` (default 4). `carry_out` is always the carry out of the top adder stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Operand always fed to the adder |
| op_b | input | WIDTH | Operand routed through the selector |
| y_sel | input | 2 | Selector code: 00 B, 01 inverted B, 10 zeros, 11 ones |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top stage |

## Verification
At the default width the bench sweeps every combination of A, B, code and carry-in, so each of the eight table rows is checked against every operand pair. The operand pairs include equal operands, which separate subtract from subtract-with-borrow through `carry_out`. All-ones and zero values of A expose the wrap of increment and decrement. In the rows that ignore B, varying B while holding A shows any leak of B into the result.

// File: rtl/arith_unit.sv
module arith_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       y_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] y_opnd;
  logic [WIDTH:0]   cy;

  assign cy[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (y_sel)
        2'b00:   y_opnd[i] = op_b[i];
        2'b01:   y_opnd[i] = ~op_b[i];
        2'b10:   y_opnd[i] = 1'b0;
        default: y_opnd[i] = 1'b1;
      endcase
    end
    assign result[i] = op_a[i] ^ y_opnd[i] ^ cy[i];
    assign cy[i+1]   = (op_a[i] & y_opnd[i]) | (cy[i] & (op_a[i] ^ y_opnd[i]));
  end

  assign carry_out = cy[WIDTH];
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       y_sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH-1:0] a_minus_b;
  logic [WIDTH-1:0] a_plus_one;
  logic [WIDTH-1:0] a_minus_one;

  always_comb begin
    a_minus_b   = op_a - op_b;
    a_plus_one  = op_a + 1'b1;
    a_minus_one = op_a - 1'b1;
    if (y_sel == 2'b01 && carry_in)
      assert_sub_R3: assert (result == a_minus_b && carry_out == (op_a >= op_b));
    if (y_sel == 2'b01 && !carry_in)
      assert_borrow_R4: assert (carry_out == (op_a > op_b));
    if (y_sel == 2'b10 && !carry_in)
      assert_pass_R5: assert (result == op_a && !carry_out);
    if (y_sel == 2'b10 && carry_in)
      assert_inc_R6: assert (result == a_plus_one && carry_out == (&op_a));
    if (y_sel == 2'b11 && !carry_in)
      assert_dec_R7: assert (result == a_minus_one && carry_out == (|op_a));
    if (y_sel == 2'b11 && carry_in)
      assert_pass_R8: assert (result == op_a && carry_out);
  end
endmodule

bind arith_unit arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .y_sel(y_sel), .carry_in(carry_in),
  .result(result), .carry_out(carry_out)
);

// File: tb/arith_unit_tb.sv
module arith_unit_tb;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0]   y_sel = 2'b00;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  arith_unit #(.WIDTH(W)) u_dut (
    .op_a(op_a), .op_b(op_b), .y_sel(y_sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d sel=%0d cin=%0d act=%0d exp=%0d",
               tag, op_a, op_b, y_sel, carry_in, act, exp);
    end
  endtask

  task automatic apply_and_check(int a, int b, int s, int c);
    int ed, ec, sum;
    string tag;
    @(posedge clk);
    op_a = W'(a); op_b = W'(b); y_sel = 2'(s); carry_in = 1'(c);
    case ({s[1:0], c[0]})
      3'b000: begin tag = "R1"; sum = a + b;     ed = sum % M; ec = int'(sum >= M); end
      3'b001: begin tag = "R2"; sum = a + b + 1; ed = sum % M; ec = int'(sum >= M); end
      3'b011: begin tag = "R3"; ed = (a - b + M) % M;     ec = int'(a >= b); end
      3'b010: begin tag = "R4"; ed = (a - b - 1 + M) % M; ec = int'(a > b); end
      3'b100: begin tag = "R5"; ed = a;               ec = 0; end
      3'b101: begin tag = "R6"; ed = (a + 1) % M;     ec = int'(a == M - 1); end
      3'b110: begin tag = "R7"; ed = (a - 1 + M) % M; ec = int'(a != 0); end
      default: begin tag = "R8"; ed = a;              ec = 1; end
    endcase
    @(negedge clk);
    check({tag, " result"}, int'(result), ed);
    check({tag, " carry R9"}, int'(carry_out), ec);
  endtask

  initial begin
    @(negedge clk);
    check("R1 idle result", int'(result), 0);
    check("R1 idle carry", int'(carry_out), 0);
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < M; a++)
          for (int b = 0; b < M; b++)
            apply_and_check(a, b, s, c);
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
  end

  initial begin
    wait (done || checks < 0);
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule